// File: doc/BRIEF.md
# 100BASE-X Receive Code-Group Decoder

This block sits after symbol alignment in a fast-Ethernet receive path. Every symbol clock it takes one aligned 5-bit code group and turns the stream into the three media-independent receive outputs: a data nibble, a data-valid flag and an error flag. It looks for the two-group start delimiter while idle. Inside a frame it maps each data group back to its 4-bit value. A frame closes cleanly on the two-group end delimiter.

Any stream that breaks those rules is reported on the error flag. A start delimiter that goes wrong gives a fixed nibble and leaves data-valid low. An unknown group inside a frame is flagged while data-valid is still high. A frame that runs into idle or ends with a broken end delimiter is flagged with data-valid low. After any error the block ignores the line until it sees a run of idle groups. Outputs are launched on the falling clock edge so that the receiver can sample them on the rising edge.

Top module: `rx_group_decoder`

## Requirements
- R1: While reset is held low, rxValid, rxError and rxNibble are all 0.
- R2: Inside a frame, each data group gives rxValid=1, rxError=0 and the nibble from the 4B/5B table: 0=11110 1=01001 2=10100 3=10101 4=01010 5=01011 6=01110 7=01111 8=10010 9=10011 A=10110 B=10111 C=11010 D=11011 E=11100 F=11101.
- R3: Idle (11111), a start pair (11000 then 10001) seen in idle, and an end pair (01101 then 00111) closing a frame each give rxValid=0 and rxError=0 in their cycles.
- R4: In idle, any group other than idle or the first start group is a bad start delimiter. A second group other than 10001 after the first start group is also a bad start delimiter. Either one gives rxError=1, rxNibble=1110 and rxValid=0.
- R5: Inside a frame, a group that is not data, not 01101 and not 11111 gives rxError=1 with rxValid=1 in that cycle. From the next cycle on, rxValid stays 0.
- R6: An end-delimiter group 01101 followed by anything other than 00111 gives rxError=1 and rxValid=0 on that second group.
- R7: An idle group inside a frame (premature end) gives rxError=1 and rxValid=0 in that cycle.
- R8: After any error, no frame is started until IDLE_RUN (default 2) consecutive idle groups have arrived. A premature-end idle counts as the first of them. Start pairs before that produce no output.
- R9: The outputs change only on the falling clock edge and hold still across each rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Symbol clock, one code group per cycle |
| rstN | input | 1 | Asynchronous active-low reset |
| codeGroup | input | 5 | Aligned receive code group, sampled on the rising edge |
| rxNibble | output | 4 | Receive data nibble |
| rxValid | output | 1 | Receive data valid |
| rxError | output | 1 | Receive error |

## Verification
The assertions assume that codeGroup is stable around each rising clock edge and that exactly one group arrives per cycle. With that assumption, the group sampled on one rising edge is the cause of the outputs seen at the next rising edge. The bench changes codeGroup only half a cycle after a rising edge and feeds one group per step. Frames are built from fixed-seed random lengths and payloads. Every frame is framed by at least two idles, so each one begins from the idle state.

// File: rtl/rxdec_pkg.sv
package rxdec_pkg;
  localparam int GW = 5;
  localparam int NW = 4;
  localparam int NIB_COUNT = 1 << NW;

  localparam logic [GW-1:0] GRP_IDLE  = 5'b11111;
  localparam logic [GW-1:0] GRP_START = 5'b11000;
  localparam logic [GW-1:0] GRP_SECND = 5'b10001;
  localparam logic [GW-1:0] GRP_TERM  = 5'b01101;
  localparam logic [GW-1:0] GRP_RESET = 5'b00111;
  localparam logic [NW-1:0] NIB_BADSTART = 4'b1110;

  typedef enum logic [2:0] {
    ST_IDLE, ST_GOTJ, ST_DATA, ST_GOTT, ST_HOLD
  } rxState_e;

  typedef enum logic [1:0] {NIB_ZERO, NIB_DATA, NIB_SSD} nibSel_e;

  typedef struct packed {
    logic    dv;
    logic    er;
    nibSel_e sel;
  } outStrobe_t;

  typedef struct packed {
    logic isData;
    logic isIdle;
    logic isJ;
    logic isK;
    logic isT;
    logic isR;
  } grpClass_t;

  function automatic logic [GW-1:0] dataCode(input logic [NW-1:0] n);
    case (n)
      4'h0: dataCode = 5'b11110;  4'h1: dataCode = 5'b01001;
      4'h2: dataCode = 5'b10100;  4'h3: dataCode = 5'b10101;
      4'h4: dataCode = 5'b01010;  4'h5: dataCode = 5'b01011;
      4'h6: dataCode = 5'b01110;  4'h7: dataCode = 5'b01111;
      4'h8: dataCode = 5'b10010;  4'h9: dataCode = 5'b10011;
      4'hA: dataCode = 5'b10110;  4'hB: dataCode = 5'b10111;
      4'hC: dataCode = 5'b11010;  4'hD: dataCode = 5'b11011;
      4'hE: dataCode = 5'b11100;  default: dataCode = 5'b11101;
    endcase
  endfunction
endpackage

// File: rtl/rxdec_datapath.sv
module rxdec_datapath
  import rxdec_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic [GW-1:0] codeGroup,
  input  outStrobe_t    strobe,
  output grpClass_t     cls,
  output logic [NW-1:0] rxNibble,
  output logic          rxValid,
  output logic          rxError
);
  logic [GW-1:0]        grpQ;
  logic [NIB_COUNT-1:0] hit;
  logic [NW-1:0]        dataNib;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) grpQ <= GRP_IDLE;
    else       grpQ <= codeGroup;
  end

  for (genvar i = 0; i < NIB_COUNT; i++) begin : g_match
    assign hit[i] = (grpQ == dataCode(NW'(i)));
  end

  always_comb begin
    dataNib = '0;
    for (int i = 0; i < NIB_COUNT; i++)
      if (hit[i]) dataNib = dataNib | NW'(i);
  end

  always_comb begin
    cls.isData = |hit;
    cls.isIdle = (grpQ == GRP_IDLE);
    cls.isJ    = (grpQ == GRP_START);
    cls.isK    = (grpQ == GRP_SECND);
    cls.isT    = (grpQ == GRP_TERM);
    cls.isR    = (grpQ == GRP_RESET);
  end

  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) begin
      rxNibble <= '0;
      rxValid  <= 1'b0;
      rxError  <= 1'b0;
    end else begin
      rxValid <= strobe.dv;
      rxError <= strobe.er;
      case (strobe.sel)
        NIB_DATA: rxNibble <= dataNib;
        NIB_SSD:  rxNibble <= NIB_BADSTART;
        default:  rxNibble <= '0;
      endcase
    end
  end
endmodule

// File: rtl/rxdec_ctrl.sv
module rxdec_ctrl
  import rxdec_pkg::*;
#(
  parameter int IDLE_RUN = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  grpClass_t  cls,
  output outStrobe_t strobe
);
  localparam int CW = $clog2(IDLE_RUN + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(IDLE_RUN - 1);

  rxState_e state, nextState;
  logic [CW-1:0] idleCnt, nextCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      idleCnt <= '0;
    end else begin
      state   <= nextState;
      idleCnt <= nextCnt;
    end
  end

  always_comb begin
    nextState = state;
    nextCnt   = idleCnt;
    strobe    = '{dv: 1'b0, er: 1'b0, sel: NIB_ZERO};
    case (state)
      ST_IDLE: begin
        if (cls.isJ) nextState = ST_GOTJ;
        else if (!cls.isIdle) begin
          strobe.er  = 1'b1;
          strobe.sel = NIB_SSD;
          nextState  = ST_HOLD;
          nextCnt    = '0;
        end
      end
      ST_GOTJ: begin
        if (cls.isK) nextState = ST_DATA;
        else begin
          strobe.er  = 1'b1;
          strobe.sel = NIB_SSD;
          nextState  = ST_HOLD;
          nextCnt    = '0;
        end
      end
      ST_DATA: begin
        if (cls.isData) begin
          strobe.dv  = 1'b1;
          strobe.sel = NIB_DATA;
        end else if (cls.isT) nextState = ST_GOTT;
        else begin
          strobe.er = 1'b1;
          strobe.dv = !cls.isIdle;
          nextCnt   = cls.isIdle ? CW'(1) : '0;
          nextState = (cls.isIdle && IDLE_RUN <= 1) ? ST_IDLE : ST_HOLD;
        end
      end
      ST_GOTT: begin
        if (cls.isR) nextState = ST_IDLE;
        else begin
          strobe.er = 1'b1;
          nextCnt   = cls.isIdle ? CW'(1) : '0;
          nextState = (cls.isIdle && IDLE_RUN <= 1) ? ST_IDLE : ST_HOLD;
        end
      end
      default: begin
        if (!cls.isIdle) nextCnt = '0;
        else if (idleCnt >= CNT_LAST) begin
          nextState = ST_IDLE;
          nextCnt   = '0;
        end else nextCnt = idleCnt + CW'(1);
      end
    endcase
  end
endmodule

// File: rtl/rx_group_decoder.sv
module rx_group_decoder
  import rxdec_pkg::*;
#(
  parameter int IDLE_RUN = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [4:0] codeGroup,
  output logic [3:0] rxNibble,
  output logic       rxValid,
  output logic       rxError
);
  grpClass_t  cls;
  outStrobe_t strobe;

  rxdec_datapath u_dp (
    .clk(clk), .rstN(rstN), .codeGroup(codeGroup), .strobe(strobe),
    .cls(cls), .rxNibble(rxNibble), .rxValid(rxValid), .rxError(rxError)
  );

  rxdec_ctrl #(.IDLE_RUN(IDLE_RUN)) u_ctrl (
    .clk(clk), .rstN(rstN), .cls(cls), .strobe(strobe)
  );
endmodule

// File: rtl/rx_group_decoder_chk.sv
module rx_group_decoder_chk
  import rxdec_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic [4:0] codeGroup,
  input logic [3:0] rxNibble,
  input logic       rxValid,
  input logic       rxError
);
  AST_DATA_MATCHES_GROUP: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && !rxError) |-> (dataCode(rxNibble) == $past(codeGroup))); // R2

  AST_IDLE_TERM_NO_VALID: assert property (@(posedge clk) disable iff (!rstN)
    ($past(codeGroup) == GRP_IDLE || $past(codeGroup) == GRP_TERM) |-> !rxValid); // R3

  AST_BADSTART_NIBBLE: assert property (@(posedge clk) disable iff (!rstN)
    (rxError && rxNibble != 4'h0) |-> (rxNibble == NIB_BADSTART && !rxValid)); // R4

  AST_ERR_CLOSES_FRAME: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && rxError) |=> !rxValid); // R5

  AST_ERR_REARM_GAP: assert property (@(posedge clk) disable iff (!rstN)
    rxError |=> !rxValid ##1 !rxValid); // R8

  always @(posedge clk)
    if (!rstN) AST_RESET_QUIET: assert (!rxValid && !rxError); // R1
endmodule

bind rx_group_decoder rx_group_decoder_chk u_chk (.*);

// File: tb/rx_group_decoder_bench.sv
module rx_group_decoder_bench;
  localparam time CLK_PERIOD = 40ns;
  localparam logic [4:0] G_I = 5'b11111, G_J = 5'b11000, G_K = 5'b10001,
                         G_T = 5'b01101, G_R = 5'b00111;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [4:0] codeGroup = G_I;
  logic [3:0] rxNibble;
  logic rxValid, rxError;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  rx_group_decoder u_rx_group_decoder (
    .clk(clk), .rstN(rstN), .codeGroup(codeGroup),
    .rxNibble(rxNibble), .rxValid(rxValid), .rxError(rxError)
  );

  function automatic logic [4:0] enc(input logic [3:0] n);
    logic [4:0] t [16] = '{5'b11110, 5'b01001, 5'b10100, 5'b10101, 5'b01010, 5'b01011,
                           5'b01110, 5'b01111, 5'b10010, 5'b10011, 5'b10110, 5'b10111,
                           5'b11010, 5'b11011, 5'b11100, 5'b11101};
    return t[n];
  endfunction

  function automatic bit isDataGrp(input logic [4:0] g);
    for (int i = 0; i < 16; i++) if (enc(4'(i)) == g) return 1'b1;
    return 1'b0;
  endfunction

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic [4:0] g, input logic eDv, input logic eEr,
                      input logic [3:0] eNib, input bit chkNib, input string tag);
    logic pv, pe;
    logic [3:0] pn;
    pv = rxValid; pe = rxError; pn = rxNibble;
    codeGroup = g;
    @(posedge clk); #1;
    check("R9", "hold across rising edge", {rxValid, rxError, rxNibble}, {pv, pe, pn});
    @(negedge clk); #1;
    check(tag, "rxValid", rxValid, eDv);
    check(tag, "rxError", rxError, eEr);
    if (chkNib) check(tag, "rxNibble", rxNibble, eNib);
  endtask

  task automatic quiet(input logic [4:0] g, input string tag);
    step(g, 1'b0, 1'b0, 4'h0, 1'b0, tag);
  endtask

  task automatic frameHead();
    quiet(G_I, "R3"); quiet(G_I, "R3"); quiet(G_J, "R3"); quiet(G_K, "R3");
  endtask

  task automatic payload(input int n);
    for (int i = 0; i < n; i++) begin
      logic [3:0] d = 4'($urandom % 16);
      step(enc(d), 1'b1, 1'b0, d, 1'b1, "R2");
    end
  endtask

  function automatic logic [4:0] randMidBad();
    logic [4:0] g;
    do g = 5'($urandom % 32); while (isDataGrp(g) || g == G_I || g == G_T);
    return g;
  endfunction

  task automatic goodFrame(input int n);
    frameHead(); payload(n); quiet(G_T, "R3"); quiet(G_R, "R3");
  endtask

  task automatic midErrFrame(input int n);
    frameHead(); payload(n);
    step(randMidBad(), 1'b1, 1'b1, 4'h0, 1'b0, "R5");
    quiet(enc(4'($urandom % 16)), "R5"); quiet(G_T, "R5"); quiet(G_R, "R5");
    quiet(G_I, "R8"); quiet(G_I, "R8");
  endtask

  task automatic badSecondFrame();
    logic [4:0] x;
    do x = 5'($urandom % 32); while (x == G_K || x == G_I);
    quiet(G_I, "R3"); quiet(G_I, "R3"); quiet(G_J, "R3");
    step(x, 1'b0, 1'b1, 4'hE, 1'b1, "R4");
    quiet(enc(4'($urandom % 16)), "R8"); quiet(G_I, "R8"); quiet(G_I, "R8");
  endtask

  task automatic badFirstFrame();
    logic [4:0] x;
    do x = 5'($urandom % 32); while (x == G_J || x == G_I);
    quiet(G_I, "R3"); quiet(G_I, "R3");
    step(x, 1'b0, 1'b1, 4'hE, 1'b1, "R4");
    quiet(G_I, "R8"); quiet(G_I, "R8");
  endtask

  task automatic missingRFrame(input int n);
    logic [4:0] y = ($urandom % 2) ? G_I : enc(4'($urandom % 16));
    frameHead(); payload(n); quiet(G_T, "R3");
    step(y, 1'b0, 1'b1, 4'h0, 1'b0, "R6");
    quiet(G_I, "R8"); quiet(G_I, "R8");
  endtask

  task automatic prematureFrame(input int n);
    frameHead(); payload(n);
    step(G_I, 1'b0, 1'b1, 4'h0, 1'b0, "R7");
    quiet(G_I, "R8");
  endtask

  task automatic finishRun();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      check("WATCHDOG", "run completed", 0, 1);
      finishRun();
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    #1;
    check("R1", "rxValid in reset", rxValid, 0);
    check("R1", "rxError in reset", rxError, 0);
    check("R1", "rxNibble in reset", rxNibble, 0);
    rstN = 1'b1;

    frameHead();
    for (int d = 0; d < 16; d++) step(enc(4'(d)), 1'b1, 1'b0, 4'(d), 1'b1, "R2");
    quiet(G_T, "R3"); quiet(G_R, "R3");

    quiet(G_I, "R3");
    step(G_K, 1'b0, 1'b1, 4'hE, 1'b1, "R4");
    quiet(G_I, "R8"); quiet(G_J, "R8"); quiet(G_K, "R8");
    quiet(enc(4'h5), "R8"); quiet(G_T, "R8"); quiet(G_R, "R8");
    quiet(G_I, "R8"); quiet(G_I, "R8");
    goodFrame(3);

    frameHead(); payload(2);
    step(G_I, 1'b0, 1'b1, 4'h0, 1'b0, "R7");
    quiet(G_I, "R8"); quiet(G_J, "R8"); quiet(G_K, "R8");
    step(enc(4'hA), 1'b1, 1'b0, 4'hA, 1'b1, "R8");
    quiet(G_T, "R3"); quiet(G_R, "R3");

    frameHead();
    step(G_J, 1'b1, 1'b1, 4'h0, 1'b0, "R5");
    quiet(enc(4'h1), "R5"); quiet(G_I, "R8"); quiet(G_I, "R8");

    for (int f = 0; f < 120; f++) begin
      int n = 1 + int'($urandom % 12);
      case ($urandom % 6)
        0: goodFrame(n);
        1: midErrFrame(n);
        2: badSecondFrame();
        3: badFirstFrame();
        4: missingRFrame(n);
        default: prematureFrame(n);
      endcase
    end
    goodFrame(4);
    done = 1;
    finishRun();
  end
endmodule